// File: doc/BRIEF.md
# I2C Error Condition Monitor

This block watches the bit-level activity of an I2C controller and the state of its byte engine. It detects four kinds of transfer error and keeps a sticky flag for each one. A start or stop condition that lands inside a byte is a bus error. A byte sent without an acknowledge is an acknowledge failure. Seeing SDA low while the block releases it is an arbitration loss. A full or empty data register that the engine cannot stretch its way out of is an overrun or underrun. A single error interrupt is raised while any flag is set and the interrupt enable is high.

Each error kind also has its own recovery command to the byte engine, sent as a one-cycle pulse: release the bus, drop the partial or new byte, resend the previous byte, treat a misplaced start as a repeated start, or fall back to slave mode. After an arbitration loss, a level output keeps the engine from answering its own address until the next start. Software clears a flag by writing zero to its bit. While the bus is idle, between a stop and the next start, no errors are flagged.

Flag vector layout: bit 0 bus error, bit 1 arbitration lost, bit 2 acknowledge failure, bit 3 overrun/underrun.

Top module: `i2c_err_mon`

## Requirements
- R1: While the bus is busy, a start or stop pulse that arrives while `byte_busy_i` is high sets the bus-error flag (`flags_o[0]`).
- R2: On a bus error in slave mode, `release_bus_o` and `discard_byte_o` pulse. If the bus error was caused by a start, `restart_o` also pulses. A misplaced stop ends the busy period in the same way as a normal stop.
- R3: On a bus error in master mode, only the flag is set. No release, discard or restart command is issued.
- R4: While the bus is busy and `tx_i` is high, an `ack_slot_i` pulse that samples `ack_sample_i`=1 (NACK) sets `flags_o[2]`. In slave mode it also pulses `release_bus_o`. In master mode only the flag is set.
- R5: While the bus is busy in master transmit, an `scl_rise_i` pulse with `sda_drv_i`=1 and `sda_in_i`=0 sets `flags_o[1]` and pulses `release_bus_o` and `force_slave_o`. It also raises `addr_mute_o`, which stays high until the next start pulse.
- R6: In slave receive with `stretch_en_i`=0, a `byte_done_i` pulse while `dr_full_i`=1 sets `flags_o[3]` and pulses `discard_byte_o`.
- R7: In slave transmit with `stretch_en_i`=0, an `scl_rise_i` pulse on `first_bit_i` while `dr_full_i`=0 sets `flags_o[3]` and pulses `repeat_byte_o`.
- R8: Overrun or underrun is never flagged in master mode or while `stretch_en_i`=1.
- R9: Flags are sticky. A `flag_wr_i` pulse clears every flag whose `flag_wdata_i` bit is 0 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: `err_irq_o` equals `err_ie_i` ANDed with the OR of all flags.
- R11: No flag or command is produced while the bus is idle: after reset, or after a stop and before the next start.
- R12: Flags, commands and `addr_mute_o` change on the clock edge that samples the causing inputs. Commands stay high for one cycle per event. Reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_det_i | input | 1 | Start condition detected (pulse) |
| stop_det_i | input | 1 | Stop condition detected (pulse) |
| byte_busy_i | input | 1 | Address or data bits of a byte in progress |
| first_bit_i | input | 1 | Current bit is the first of a byte |
| scl_rise_i | input | 1 | SCL rising edge (pulse) |
| byte_done_i | input | 1 | Last data bit of a received byte sampled (pulse) |
| ack_slot_i | input | 1 | Acknowledge bit sampled (pulse) |
| ack_sample_i | input | 1 | Sampled acknowledge level, 1 = NACK |
| sda_drv_i | input | 1 | Level the block drives on SDA, 1 = released |
| sda_in_i | input | 1 | Sampled SDA level |
| master_i | input | 1 | 1 = master mode |
| tx_i | input | 1 | 1 = transmitter |
| stretch_en_i | input | 1 | Clock stretching allowed |
| dr_full_i | input | 1 | Data register holds a byte (unread on receive, loaded on transmit) |
| err_ie_i | input | 1 | Error interrupt enable |
| flag_wr_i | input | 1 | Software write to the flags (pulse) |
| flag_wdata_i | input | 4 | Write data, a 0 bit clears that flag |
| flags_o | output | 4 | Sticky error flags |
| err_irq_o | output | 1 | Error interrupt |
| release_bus_o | output | 1 | Release SCL/SDA command |
| force_slave_o | output | 1 | Switch-to-slave command |
| discard_byte_o | output | 1 | Drop the partial or newly received byte |
| repeat_byte_o | output | 1 | Send the previous data register contents again |
| restart_o | output | 1 | Treat the misplaced start as a repeated start |
| addr_mute_o | output | 1 | Do not answer the own address until the next start |

## Verification
The assertions assume that the byte engine never raises a start and a stop in the same cycle. They also assume that each detector strobe lasts exactly one clock. Under those assumptions, a rising bus-error flag can be traced back to a start or stop strobe, and a discard command can be traced back to slave mode. The random stimulus uses mutually exclusive start and stop strobes and drives every input anew each cycle. The directed stimulus raises each strobe for a single cycle and then lowers it before the next step.

// File: rtl/i2c_err_pkg.sv
package i2c_err_pkg;
  localparam int unsigned ERR_W = 4;

  typedef enum logic [1:0] {
    ERR_BUS = 2'd0,
    ERR_ARB = 2'd1,
    ERR_ACK = 2'd2,
    ERR_OVR = 2'd3
  } err_idx_e;

  typedef struct packed {
    logic release_bus;
    logic force_slave;
    logic discard;
    logic resend;
    logic restart;
  } cmd_t;

  localparam cmd_t CMD_NONE = '0;
endpackage

// File: rtl/i2c_err_busmon.sv
module i2c_err_busmon
  import i2c_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic byte_busy_i,
  input  logic master_i,
  output logic busy_o,
  output logic berr_set_o,
  output cmd_t cmd_o
);
  logic busy_q;

  // start wins over stop; stop also closes a busy period after a misplaced stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (start_det_i) busy_q <= 1'b1;
    else if (stop_det_i)  busy_q <= 1'b0;
  end

  assign busy_o     = busy_q;
  assign berr_set_o = busy_q & byte_busy_i & (start_det_i | stop_det_i);

  always_comb begin
    cmd_o             = CMD_NONE;
    cmd_o.release_bus = berr_set_o & ~master_i;
    cmd_o.discard     = berr_set_o & ~master_i;
    cmd_o.restart     = berr_set_o & ~master_i & start_det_i;
  end
endmodule

// File: rtl/i2c_err_xfer.sv
module i2c_err_xfer
  import i2c_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic start_det_i,
  input  logic master_i,
  input  logic tx_i,
  input  logic scl_rise_i,
  input  logic sda_drv_i,
  input  logic sda_in_i,
  input  logic ack_slot_i,
  input  logic ack_sample_i,
  output logic arlo_set_o,
  output logic af_set_o,
  output logic mute_o,
  output cmd_t cmd_o
);
  logic mute_q;

  // released-high SDA read back low on an SCL rise: another master won
  assign arlo_set_o = busy_i & master_i & tx_i & scl_rise_i & sda_drv_i & ~sda_in_i;
  assign af_set_o   = busy_i & tx_i & ack_slot_i & ack_sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mute_q <= 1'b0;
    else if (arlo_set_o)  mute_q <= 1'b1;
    else if (start_det_i) mute_q <= 1'b0;
  end

  assign mute_o = mute_q;

  always_comb begin
    cmd_o             = CMD_NONE;
    cmd_o.release_bus = arlo_set_o | (af_set_o & ~master_i);
    cmd_o.force_slave = arlo_set_o;
  end
endmodule

// File: rtl/i2c_err_ovr.sv
module i2c_err_ovr
  import i2c_err_pkg::*;
(
  input  logic busy_i,
  input  logic master_i,
  input  logic tx_i,
  input  logic stretch_en_i,
  input  logic byte_done_i,
  input  logic first_bit_i,
  input  logic scl_rise_i,
  input  logic dr_full_i,
  output logic ovr_set_o,
  output cmd_t cmd_o
);
  logic slave_fixed_clk;
  logic rx_overrun;
  logic tx_underrun;

  assign slave_fixed_clk = busy_i & ~master_i & ~stretch_en_i;
  assign rx_overrun      = slave_fixed_clk & ~tx_i & byte_done_i & dr_full_i;
  assign tx_underrun     = slave_fixed_clk & tx_i & first_bit_i & scl_rise_i & ~dr_full_i;
  assign ovr_set_o       = rx_overrun | tx_underrun;

  always_comb begin
    cmd_o         = CMD_NONE;
    cmd_o.discard = rx_overrun;
    cmd_o.resend  = tx_underrun;
  end
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ie_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  logic [W-1:0] flag_q;

  for (genvar k = 0; k < W; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  flag_q[k] <= 1'b0;
      else if (set_i[k])            flag_q[k] <= 1'b1;
      else if (wr_i && !wdata_i[k]) flag_q[k] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = ie_i & (|flag_q);
endmodule

// File: rtl/i2c_err_mon.sv
module i2c_err_mon
  import i2c_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             byte_busy_i,
  input  logic             first_bit_i,
  input  logic             scl_rise_i,
  input  logic             byte_done_i,
  input  logic             ack_slot_i,
  input  logic             ack_sample_i,
  input  logic             sda_drv_i,
  input  logic             sda_in_i,
  input  logic             master_i,
  input  logic             tx_i,
  input  logic             stretch_en_i,
  input  logic             dr_full_i,
  input  logic             err_ie_i,
  input  logic             flag_wr_i,
  input  logic [ERR_W-1:0] flag_wdata_i,
  output logic [ERR_W-1:0] flags_o,
  output logic             err_irq_o,
  output logic             release_bus_o,
  output logic             force_slave_o,
  output logic             discard_byte_o,
  output logic             repeat_byte_o,
  output logic             restart_o,
  output logic             addr_mute_o
);
  logic             busy;
  logic             berr_set, arlo_set, af_set, ovr_set;
  cmd_t             bus_cmd, xfer_cmd, ovr_cmd, cmd_d, cmd_q;
  logic [ERR_W-1:0] set_vec;

  i2c_err_busmon u_busmon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .byte_busy_i (byte_busy_i),
    .master_i    (master_i),
    .busy_o      (busy),
    .berr_set_o  (berr_set),
    .cmd_o       (bus_cmd)
  );

  i2c_err_xfer u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .start_det_i  (start_det_i),
    .master_i     (master_i),
    .tx_i         (tx_i),
    .scl_rise_i   (scl_rise_i),
    .sda_drv_i    (sda_drv_i),
    .sda_in_i     (sda_in_i),
    .ack_slot_i   (ack_slot_i),
    .ack_sample_i (ack_sample_i),
    .arlo_set_o   (arlo_set),
    .af_set_o     (af_set),
    .mute_o       (addr_mute_o),
    .cmd_o        (xfer_cmd)
  );

  i2c_err_ovr u_ovr (
    .busy_i       (busy),
    .master_i     (master_i),
    .tx_i         (tx_i),
    .stretch_en_i (stretch_en_i),
    .byte_done_i  (byte_done_i),
    .first_bit_i  (first_bit_i),
    .scl_rise_i   (scl_rise_i),
    .dr_full_i    (dr_full_i),
    .ovr_set_o    (ovr_set),
    .cmd_o        (ovr_cmd)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ERR_BUS] = berr_set;
    set_vec[ERR_ARB] = arlo_set;
    set_vec[ERR_ACK] = af_set;
    set_vec[ERR_OVR] = ovr_set;
  end

  i2c_err_flags #(.W(ERR_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .ie_i    (err_ie_i),
    .flags_o (flags_o),
    .irq_o   (err_irq_o)
  );

  assign cmd_d = bus_cmd | xfer_cmd | ovr_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_NONE;
    else         cmd_q <= cmd_d;
  end

  assign release_bus_o  = cmd_q.release_bus;
  assign force_slave_o  = cmd_q.force_slave;
  assign discard_byte_o = cmd_q.discard;
  assign repeat_byte_o  = cmd_q.resend;
  assign restart_o      = cmd_q.restart;
endmodule

// File: rtl/i2c_err_mon_chk.sv
module i2c_err_mon_chk
  import i2c_err_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_det_i,
  input logic             stop_det_i,
  input logic             byte_busy_i,
  input logic             master_i,
  input logic             err_ie_i,
  input logic             flag_wr_i,
  input logic [ERR_W-1:0] flag_wdata_i,
  input logic [ERR_W-1:0] flags_o,
  input logic             err_irq_o,
  input logic             release_bus_o,
  input logic             force_slave_o,
  input logic             discard_byte_o,
  input logic             repeat_byte_o,
  input logic             addr_mute_o
);
  assert_berr_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> $past(start_det_i || stop_det_i) && $past(byte_busy_i));

  assert_master_keeps_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_bus_o && $past(master_i)) |-> force_slave_o);

  assert_arlo_cmds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> force_slave_o && release_bus_o && addr_mute_o);

  assert_mute_on_arlo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_slave_o |-> addr_mute_o);

  assert_discard_slave_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_byte_o |-> !$past(master_i));

  assert_resend_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_byte_o |-> flags_o[3]);

  for (genvar k = 0; k < ERR_W; k++) begin : g_sticky
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_o[k]) |-> $past(flag_wr_i && !flag_wdata_i[k]));
  end

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> err_ie_i && (|flags_o));
endmodule

bind i2c_err_mon i2c_err_mon_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_det_i    (start_det_i),
  .stop_det_i     (stop_det_i),
  .byte_busy_i    (byte_busy_i),
  .master_i       (master_i),
  .err_ie_i       (err_ie_i),
  .flag_wr_i      (flag_wr_i),
  .flag_wdata_i   (flag_wdata_i),
  .flags_o        (flags_o),
  .err_irq_o      (err_irq_o),
  .release_bus_o  (release_bus_o),
  .force_slave_o  (force_slave_o),
  .discard_byte_o (discard_byte_o),
  .repeat_byte_o  (repeat_byte_o),
  .addr_mute_o    (addr_mute_o)
);

// File: tb/i2c_err_mon_tb.sv
module i2c_err_mon_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_det_i = 0, stop_det_i = 0, byte_busy_i = 0, first_bit_i = 0;
  logic scl_rise_i = 0, byte_done_i = 0, ack_slot_i = 0, ack_sample_i = 0;
  logic sda_drv_i = 0, sda_in_i = 0, master_i = 0, tx_i = 0, stretch_en_i = 0;
  logic dr_full_i = 0, err_ie_i = 0, flag_wr_i = 0;
  logic [3:0] flag_wdata_i = 4'hF;
  logic [3:0] flags_o;
  logic err_irq_o, release_bus_o, force_slave_o, discard_byte_o;
  logic repeat_byte_o, restart_o, addr_mute_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  i2c_err_mon u_dut (.*);

  // behavioural reference: state after each edge
  bit m_busy, m_mute;
  bit [3:0] m_flags;
  bit m_rel, m_force, m_disc, m_rep, m_rst;

  always @(posedge clk_i) begin
    bit be, ar, af, orx, otx, sl;
    if (!rst_ni) begin
      m_busy = 0; m_mute = 0; m_flags = 0;
      m_rel = 0; m_force = 0; m_disc = 0; m_rep = 0; m_rst = 0;
    end else begin
      be  = m_busy && byte_busy_i && (start_det_i || stop_det_i);
      ar  = m_busy && master_i && tx_i && scl_rise_i && sda_drv_i && !sda_in_i;
      af  = m_busy && tx_i && ack_slot_i && ack_sample_i;
      sl  = m_busy && !master_i && !stretch_en_i;
      orx = sl && !tx_i && byte_done_i && dr_full_i;
      otx = sl && tx_i && first_bit_i && scl_rise_i && !dr_full_i;
      m_rel   = (be && !master_i) || (af && !master_i) || ar;
      m_force = ar;
      m_disc  = (be && !master_i) || orx;
      m_rep   = otx;
      m_rst   = be && !master_i && start_det_i;
      for (int k = 0; k < 4; k++) begin
        bit s;
        s = (k == 0) ? be : (k == 1) ? ar : (k == 2) ? af : (orx || otx);
        if (s) m_flags[k] = 1;
        else if (flag_wr_i && !flag_wdata_i[k]) m_flags[k] = 0;
      end
      if (ar) m_mute = 1;
      else if (start_det_i) m_mute = 0;
      if (start_det_i) m_busy = 1;
      else if (stop_det_i) m_busy = 0;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      vectors++;
      chk("R1",  "bus error flag",   flags_o[0],     m_flags[0]);
      chk("R5",  "arbitration flag", flags_o[1],     m_flags[1]);
      chk("R4",  "ack failure flag", flags_o[2],     m_flags[2]);
      chk("R6",  "overrun flag",     flags_o[3],     m_flags[3]);
      chk("R10", "irq",              err_irq_o,      err_ie_i && (|m_flags));
      chk("R2",  "release",          release_bus_o,  m_rel);
      chk("R5",  "force slave",      force_slave_o,  m_force);
      chk("R6",  "discard",          discard_byte_o, m_disc);
      chk("R7",  "repeat",           repeat_byte_o,  m_rep);
      chk("R2",  "restart",          restart_o,      m_rst);
      chk("R5",  "addr mute",        addr_mute_o,    m_mute);
    end
  end

  task automatic tick();
    @(negedge clk_i); #1;
  endtask

  task automatic quiet();
    start_det_i = 0; stop_det_i = 0; scl_rise_i = 0; byte_done_i = 0;
    ack_slot_i = 0; flag_wr_i = 0; flag_wdata_i = 4'hF;
  endtask

  task automatic pulse_start(); start_det_i = 1; tick(); quiet(); tick(); endtask
  task automatic pulse_stop();  stop_det_i = 1;  tick(); quiet(); tick(); endtask
  task automatic clear_all();   flag_wr_i = 1; flag_wdata_i = 4'h0; tick(); quiet(); tick(); endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R12: reset state is checked on the cycles below
    repeat (3) tick();
    rst_ni = 1; tick();
    err_ie_i = 1;

    // R11: idle bus ignores misplaced stop, NACK and arbitration symptoms
    byte_busy_i = 1; tx_i = 1; master_i = 1;
    stop_det_i = 1; ack_slot_i = 1; ack_sample_i = 1;
    scl_rise_i = 1; sda_drv_i = 1; sda_in_i = 0; tick(); quiet(); tick();
    byte_busy_i = 0; master_i = 0;

    // R2: slave, misplaced stop mid-byte
    pulse_start(); byte_busy_i = 1; stop_det_i = 1; tick(); quiet(); byte_busy_i = 0; tick();
    // R11: the misplaced stop ended the busy period
    byte_busy_i = 1; start_det_i = 1; tick(); quiet(); byte_busy_i = 0; tick();
    clear_all();

    // R2: slave, misplaced start mid-byte -> restart
    byte_busy_i = 1; start_det_i = 1; tick(); quiet(); byte_busy_i = 0; tick();
    // R3: master bus error keeps the bus
    master_i = 1; byte_busy_i = 1; start_det_i = 1; tick(); quiet(); byte_busy_i = 0; tick();
    // R9: partial clear keeps bit 0, then set and clear in the same cycle
    flag_wr_i = 1; flag_wdata_i = 4'b0001; tick(); quiet(); tick();
    byte_busy_i = 1; start_det_i = 1; flag_wr_i = 1; flag_wdata_i = 4'h0; tick(); quiet(); byte_busy_i = 0; tick();
    clear_all();

    // R4: NACK in master and slave transmit; ACK ignored
    tx_i = 1; ack_slot_i = 1; ack_sample_i = 0; tick(); quiet(); tick();
    ack_slot_i = 1; ack_sample_i = 1; tick(); quiet(); tick();
    clear_all();
    master_i = 0; ack_slot_i = 1; ack_sample_i = 1; tick(); quiet(); tick();
    // R10: interrupt gated by enable
    err_ie_i = 0; tick(); err_ie_i = 1; tick();
    clear_all();

    // R5: arbitration loss, mute until the next start
    master_i = 1; tx_i = 1; sda_drv_i = 1; sda_in_i = 0; scl_rise_i = 1; tick(); quiet(); tick();
    sda_drv_i = 0; repeat (3) tick();
    pulse_start();
    clear_all();

    // R6: slave receive overrun, then R8 with stretching and in master mode
    master_i = 0; tx_i = 0; dr_full_i = 1; byte_done_i = 1; tick(); quiet(); tick();
    clear_all();
    stretch_en_i = 1; byte_done_i = 1; tick(); quiet(); tick();
    stretch_en_i = 0; master_i = 1; byte_done_i = 1; tick(); quiet(); tick();
    master_i = 0; dr_full_i = 0; byte_done_i = 1; tick(); quiet(); tick();

    // R7: slave transmit underrun; refilled register gives none
    tx_i = 1; first_bit_i = 1; dr_full_i = 0; scl_rise_i = 1; tick(); quiet(); tick();
    clear_all();
    dr_full_i = 1; scl_rise_i = 1; tick(); quiet(); tick();
    stretch_en_i = 1; dr_full_i = 0; scl_rise_i = 1; tick(); quiet(); tick();
    stretch_en_i = 0; first_bit_i = 0;
    pulse_stop();

    // random traffic, start and stop never together
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      start_det_i  = (r < 3);
      stop_det_i   = (r >= 3 && r < 6);
      byte_busy_i  = $urandom % 2;
      first_bit_i  = $urandom % 2;
      scl_rise_i   = ($urandom % 3) == 0;
      byte_done_i  = ($urandom % 6) == 0;
      ack_slot_i   = ($urandom % 6) == 0;
      ack_sample_i = $urandom % 2;
      sda_drv_i    = $urandom % 2;
      sda_in_i     = $urandom % 2;
      master_i     = $urandom % 2;
      tx_i         = $urandom % 2;
      stretch_en_i = ($urandom % 4) == 0;
      dr_full_i    = $urandom % 2;
      err_ie_i     = ($urandom % 8) != 0;
      flag_wr_i    = ($urandom % 10) == 0;
      flag_wdata_i = 4'($urandom);
      tick();
    end
    quiet(); tick();

    // R12: reset mid-run clears everything
    rst_ni = 0; tick(); rst_ni = 1; tick(); tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule